// File: doc/BRIEF.md
# Two-Wire Register Port with Time Snapshot

This block is the serial access port of a timekeeping macro. It behaves as a two-wire (I2C) slave at 7-bit address 1101000 and gives an external master byte access to a 16-entry register space through a single pointer. The pointer advances after every byte moved, wraps from the last entry to the first, and is kept from one transaction to the next.

The lowest entries of the space (seven by default) hold the time of day. The clock core outside the block drives them continuously on `live_time`. Reads of those entries come from a shadow copy, not from the live bus, so a multibyte read returns one consistent instant while the clock keeps counting. The shadow is refreshed on every START, every STOP and every time the pointer wraps to entry 0. Each byte the master writes is committed while the slave drives the acknowledge, and it is reported on a one-cycle write strobe so that the clock core can load time values. The bus lines are oversampled by the system clock.

Top module: `rtc_i2c_regport`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 1101000 (0xD0 for a write, 0xD1 for a read; bit 0 set means read). For any other address it drives nothing and ignores all bytes up to the next START, so the registers and the pointer stay unchanged.
- R2: In a write, the first byte after the address loads the pointer from its low four bits. Each later byte, sent MSB first, is stored at the pointer, and the pointer then steps by one. Register g appears on `reg_q[8*g+7:8*g]`.
- R3: The pointer wraps from 0x0F to 0x00 during writes and reads alike.
- R4: A read returns bytes starting at the current pointer, which is kept across STOP and START. Entries 7 to 15 return the last value written.
- R5: Entries 0 to 6 read back as a copy of `live_time` (byte g at bits 8*g+7:8*g) taken at the most recent START, STOP or pointer wrap. Changes on `live_time` during a read do not alter the bytes of that read.
- R6: When the pointer wraps to 0x00, the copy of `live_time` is refreshed before entry 0 is sent.
- R7: The slave acknowledges by holding SDA low through the high phase of the ninth clock, and it releases SDA after that clock falls.
- R8: Each written data byte gives exactly one cycle of `wr_stb`, with `wr_addr` and `wr_data`, while the slave is driving the acknowledge. The pointer byte gives no strobe.
- R9: In a read, a NACK from the master makes the slave stop driving SDA until the next START.
- R10: A START seen at any point, also in the middle of a byte, restarts address reception. The partial byte is dropped.
- R11: After reset, SDA is not driven, all registers read as 0x00, the pointer is 0x00 and `wr_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, pull the data line low |
| live_time | input | 56 | Running time bytes from the clock core, byte g at bits 8g+7:8g |
| reg_q | output | 128 | Contents of all register entries, entry g at bits 8g+7:8g |
| wr_stb | output | 1 | One-cycle pulse for each committed write byte |
| wr_addr | output | 4 | Entry index of the committed byte |
| wr_data | output | 8 | Value of the committed byte |

## Verification
Directed runs place the pointer at 0x0E and 0x0F so that writes and reads cross the wrap. In the wrapped read, entry 0 must return the new live value, while in a plain read it must return the value from the start of the read. Changing `live_time` in the middle of a read separates a shadowed read from a live one. A wrong address, followed by bytes that would change registers, shows whether the block really goes idle. A START sent after four bits of a data byte shows whether the partial byte is dropped. Seeded random writes and reads, at random pointers and with random lengths, are compared with a bench model of the register array, the pointer and the snapshot.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } i2c_st_e;

  // Address byte matches the device when its upper seven bits equal dev.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // Pointer step with wrap to zero at the end of the register space.
  function automatic int unsigned ptr_after(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rtc_i2c_linesync.sv
module rtc_i2c_linesync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC:0] scl_pipe;
  logic [SYNC:0] sda_pipe;
  logic scl_now, scl_old, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC-1:0], sda_i};
    end
  end

  assign scl_now   = scl_pipe[SYNC-1];
  assign scl_old   = scl_pipe[SYNC];
  assign sda_q     = sda_pipe[SYNC-1];
  assign sda_old   = sda_pipe[SYNC];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_evt = scl_now & scl_old & sda_old & ~sda_q;
  assign stop_evt  = scl_now & scl_old & ~sda_old & sda_q;
endmodule

// File: rtl/rtc_i2c_ctrl.sv
module rtc_i2c_ctrl
  import rtc_i2c_pkg::*;
#(
  parameter int         NREGS    = 16,
  parameter logic [6:0] DEV_ADDR = 7'b1101000,
  localparam int        PW       = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_q,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [7:0]    rd_byte,
  output logic          sda_oe,
  output logic [PW-1:0] ptr,
  output logic          ptr_ld,
  output logic          ptr_inc,
  output logic          wr_stb,
  output logic [7:0]    wr_data
);
  i2c_st_e     st;
  logic [3:0]  cnt;
  logic [7:0]  shreg, txb;
  logic        rw, first, ackd;
  logic        quiet, wack_rise, rd_load;
  logic [PW-1:0] ptr_nxt;

  assign quiet     = ~start_evt & ~stop_evt;
  assign wack_rise = quiet && st == ST_WACK && scl_rise;
  assign ptr_ld    = wack_rise & first;
  assign wr_stb    = wack_rise & ~first;
  assign rd_load   = quiet && scl_fall && ((st == ST_AACK && rw) || (st == ST_RACK && ackd));
  assign ptr_inc   = wr_stb | rd_load;
  assign ptr_nxt   = PW'(ptr_after(32'(ptr), NREGS));
  assign wr_data   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (ptr_ld) ptr <= shreg[PW-1:0];
    else if (ptr_inc) ptr <= ptr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; shreg <= '0; txb <= '0;
      rw <= 1'b0; first <= 1'b0; ackd <= 1'b0; sda_oe <= 1'b0;
    end else if (start_evt) begin
      st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0; ackd <= 1'b0;
    end else if (stop_evt) begin
      st <= ST_IDLE; sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_q};
            cnt   <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == ST_WDAT) begin
              st <= ST_WACK; sda_oe <= 1'b1;
            end else if (addr_hit(shreg, DEV_ADDR)) begin
              st <= ST_AACK; sda_oe <= 1'b1; rw <= shreg[0];
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt <= '0; ackd <= 1'b0;
          if (rw) begin
            st <= ST_RDAT; txb <= rd_byte; sda_oe <= ~rd_byte[7];
          end else begin
            st <= ST_WDAT; first <= 1'b1; sda_oe <= 1'b0;
          end
        end
        ST_WACK: begin
          if (ptr_ld) first <= 1'b0;
          if (scl_fall) begin
            st <= ST_WDAT; sda_oe <= 1'b0;
          end
        end
        ST_RDAT: if (scl_fall) begin
          if (cnt == 4'd7) begin
            st <= ST_RACK; sda_oe <= 1'b0;
          end else begin
            cnt <= cnt + 4'd1; txb <= {txb[6:0], 1'b0}; sda_oe <= ~txb[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (sda_q) st <= ST_IDLE;
            else ackd <= 1'b1;
          end else if (scl_fall && ackd) begin
            st <= ST_RDAT; txb <= rd_byte; sda_oe <= ~rd_byte[7];
            cnt <= '0; ackd <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_i2c_regbank.sv
module rtc_i2c_regbank #(
  parameter int  NREGS  = 16,
  parameter int  TBYTES = 7,
  localparam int PW     = $clog2(NREGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snap,
  input  logic                wr_stb,
  input  logic [PW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [TBYTES*8-1:0] live_time,
  input  logic [PW-1:0]       rd_addr,
  output logic [7:0]          rd_data,
  output logic [NREGS*8-1:0]  reg_q,
  output logic [TBYTES*8-1:0] shadow_q
);
  logic [7:0] view [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [7:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (wr_stb && wr_addr == PW'(g)) r <= wr_data;
    end
    assign reg_q[g*8 +: 8] = r;
    if (g < TBYTES) begin : g_time
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_q[g*8 +: 8] <= '0;
        else if (snap) shadow_q[g*8 +: 8] <= live_time[g*8 +: 8];
      end
      assign view[g] = shadow_q[g*8 +: 8];
    end else begin : g_plain
      assign view[g] = r;
    end
  end

  assign rd_data = view[rd_addr];
endmodule

// File: rtl/rtc_i2c_regport.sv
module rtc_i2c_regport #(
  parameter int         NREGS       = 16,
  parameter int         TIME_BYTES  = 7,
  parameter logic [6:0] DEV_ADDR    = 7'b1101000,
  parameter int         SYNC_STAGES = 2,
  localparam int        PW          = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  input  logic [TIME_BYTES*8-1:0] live_time,
  output logic [NREGS*8-1:0]      reg_q,
  output logic                    wr_stb,
  output logic [PW-1:0]           wr_addr,
  output logic [7:0]              wr_data
);
  logic sda_q, scl_rise, scl_fall, start_evt, stop_evt;
  logic ptr_ld, ptr_inc, wrap_evt, snap_evt;
  logic [PW-1:0] ptr;
  logic [7:0] rd_byte;
  logic [TIME_BYTES*8-1:0] shadow_q;

  rtc_i2c_linesync #(.SYNC(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  rtc_i2c_ctrl #(.NREGS(NREGS), .DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_byte(rd_byte), .sda_oe(sda_oe),
    .ptr(ptr), .ptr_ld(ptr_ld), .ptr_inc(ptr_inc), .wr_stb(wr_stb), .wr_data(wr_data)
  );

  assign wrap_evt = ptr_inc && ptr == PW'(NREGS - 1);
  assign snap_evt = start_evt | stop_evt | wrap_evt;
  assign wr_addr  = ptr;

  rtc_i2c_regbank #(.NREGS(NREGS), .TBYTES(TIME_BYTES)) bank_i (
    .clk(clk), .rst_n(rst_n), .snap(snap_evt), .wr_stb(wr_stb), .wr_addr(ptr),
    .wr_data(wr_data), .live_time(live_time), .rd_addr(ptr), .rd_data(rd_byte),
    .reg_q(reg_q), .shadow_q(shadow_q)
  );
endmodule

// File: rtl/rtc_i2c_regport_chk.sv
module rtc_i2c_regport_chk #(
  parameter int PW = 4,
  parameter int TB = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          wr_stb,
  input logic          scl_fall,
  input logic          start_evt,
  input logic          stop_evt,
  input logic [PW-1:0] ptr,
  input logic          ptr_ld,
  input logic [TB*8-1:0] live_time,
  input logic [TB*8-1:0] shadow_q
);
  AST_COMMIT_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> sda_oe); // R8

  AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt)); // R7

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr) && !$past(ptr_ld)) |-> (ptr == PW'($past(ptr) + 1'b1))); // R2

  AST_WRAP_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr) == {PW{1'b1}} && ptr == '0 && !$past(ptr_ld)) |-> (shadow_q == $past(live_time))); // R6

  AST_START_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (shadow_q == $past(live_time))); // R5

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe); // R9
endmodule

bind rtc_i2c_regport rtc_i2c_regport_chk #(.PW(PW), .TB(TIME_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wr_stb(wr_stb), .scl_fall(scl_fall),
  .start_evt(start_evt), .stop_evt(stop_evt), .ptr(ptr), .ptr_ld(ptr_ld),
  .live_time(live_time), .shadow_q(shadow_q)
);

// File: tb/rtc_i2c_regport_tb.sv
module rtc_i2c_regport_tb_top;
  localparam int         TB  = 7;
  localparam int         NR  = 16;
  localparam int         Q   = 6;
  localparam logic [6:0] DEV = 7'b1101000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_stb, sda_line;
  logic [TB*8-1:0] live = '0;
  logic [NR*8-1:0] reg_q;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;

  int errors = 0, checks = 0, wr_cnt = 0, wr_bad = 0;
  logic [7:0] mem [NR];
  logic [3:0] mptr = '0;
  logic [7:0] wbuf [8];

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  rtc_i2c_regport dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .live_time(live), .reg_q(reg_q), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) if (wr_stb) wr_cnt <= wr_cnt + 1;
  always @(negedge clk) if (wr_stb && !sda_oe) wr_bad <= wr_bad + 1;

  function automatic logic [7:0] exp_view(input logic [3:0] a, input logic [TB*8-1:0] snap);
    return (a < TB) ? snap[a*8 +: 8] : mem[a];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask
  task automatic i2c_start; sda_m = 1; qw; scl_m = 1; qw; sda_m = 0; qw; scl_m = 0; qw; endtask
  task automatic i2c_stop;  sda_m = 0; qw; scl_m = 1; qw; sda_m = 1; qw; endtask
  task automatic send_bit(input logic b); sda_m = b; qw; scl_m = 1; qw; qw; scl_m = 0; qw; endtask
  task automatic recv_bit(output logic b);
    sda_m = 1; qw; scl_m = 1; qw; b = sda_line; qw; scl_m = 0; qw;
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack);
  endtask

  task automatic check_regs(input string tag);
    for (int g = 0; g < NR; g++) chk(tag, reg_q[g*8 +: 8], mem[g]);
  endtask

  // Address + pointer + n data bytes from wbuf; stop optional.
  task automatic write_seq(input logic [7:0] pb, input int n, input bit do_stop, input string tag);
    logic a;
    i2c_start;
    send_byte({DEV, 1'b0}, a); chk({tag, " R1 addr ack"}, a, 0);
    chk({tag, " R7 release after ack"}, sda_oe, 0);
    send_byte(pb, a); chk({tag, " R7 ptr ack"}, a, 0);
    mptr = pb[3:0];
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); chk({tag, " R7 data ack"}, a, 0);
      mem[mptr] = wbuf[k];
      mptr = mptr + 4'd1;
    end
    if (do_stop) i2c_stop;
  endtask

  // Read n bytes (restart if a transaction is open); live becomes after_live during byte 0.
  task automatic read_seq(input int n, input logic [TB*8-1:0] after_live, input string tag);
    logic a, b;
    logic [7:0] d, e;
    logic [TB*8-1:0] snap, cur;
    i2c_start;
    snap = live; cur = live;
    send_byte({DEV, 1'b1}, a); chk({tag, " R1 read addr ack"}, a, 0);
    for (int k = 0; k < n; k++) begin
      if (k == 1) cur = after_live;
      e = exp_view(mptr, snap);
      if (mptr == 4'hF) snap = cur;
      mptr = mptr + 4'd1;
      for (int i = 7; i >= 0; i--) begin
        recv_bit(b); d[i] = b;
        if (k == 0 && i == 4) live = after_live;
      end
      chk({tag, " R4 R5 read byte"}, d, e);
      send_bit(k == n - 1);
    end
    chk({tag, " R9 released after nack"}, sda_oe, 0);
    i2c_stop;
    chk({tag, " R9 released after stop"}, sda_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic a;
    int n0;
    void'($urandom(17));
    for (int g = 0; g < NR; g++) mem[g] = '0;
    live = 56'h06_05_04_03_02_01_00;
    repeat (10) @(negedge clk);
    chk("R11 sda_oe at reset", sda_oe, 0);
    chk("R11 wr_stb at reset", wr_stb, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check_regs("R11 regs after reset");
    chk("R11 no drive idle", sda_oe, 0);

    // R2 R8: basic write at 8
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    n0 = wr_cnt;
    write_seq(8'h08, 2, 1, "D-write");
    check_regs("R2 write at 8");
    chk("R8 strobe count", wr_cnt - n0, 2);

    // R4: pointer-only write, stop, then a new read from it
    write_seq(8'h08, 0, 1, "D-ptr");
    read_seq(2, live, "D-persist");

    // R3: write across wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    write_seq(8'h0F, 2, 1, "D-wrapw");
    check_regs("R3 write wrap");
    chk("R3 entry0", reg_q[7:0], 8'h22);

    // R1: wrong address ignored
    n0 = wr_cnt;
    i2c_start;
    send_byte({7'h28, 1'b0}, a); chk("R1 wrong addr no ack", a, 1);
    send_byte(8'h09, a); chk("R1 no ack after mismatch", a, 1);
    send_byte(8'hFF, a);
    i2c_stop;
    check_regs("R1 regs unchanged");
    chk("R1 no strobe", wr_cnt - n0, 0);
    read_seq(1, live, "D-ptrkept");

    // R10: restart in the middle of a data byte
    n0 = wr_cnt;
    i2c_start;
    send_byte({DEV, 1'b0}, a); send_byte(8'h05, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    wbuf[0] = 8'h77;
    write_seq(8'h06, 1, 1, "D-restart");
    check_regs("R10 partial byte dropped");
    chk("R10 one strobe", wr_cnt - n0, 1);

    // R5 R10: snapshot held during read entered by repeated start
    live = 56'h59_31_23_15_04_12_30;
    write_seq(8'h00, 0, 0, "D-snap");
    read_seq(8, 56'h00_00_00_00_00_00_11, "D-snapread");

    // R6: read crossing wrap picks up the new live value at entry 0
    live = 56'h01_02_03_04_05_06_07;
    write_seq(8'h0E, 0, 0, "D-wrapr");
    read_seq(4, 56'hAA_BB_CC_DD_EE_FF_99, "D-wrapread");

    // random mix
    for (int it = 0; it < 14; it++) begin
      int n;
      logic [7:0] p;
      n = 1 + int'($urandom_range(3, 0));
      p = 8'($urandom);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      n0 = wr_cnt;
      write_seq(p, n, 1, "RND-w");
      check_regs("R2 R3 random write");
      chk("R8 random strobes", wr_cnt - n0, n);
      live = 56'({$urandom, $urandom});
      write_seq(8'($urandom), 0, 0, "RND-p");
      read_seq(1 + int'($urandom_range(4, 0)), 56'({$urandom, $urandom}), "RND-r");
    end
    chk("R8 strobes only during ack", wr_bad, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule